// File: doc/BRIEF.md
# DMA Request Header Segmenter

This block accepts one bulk transfer descriptor at a time: a start address, a byte count and a read/write flag. It cuts the transfer into a run of memory request headers for a packet-based serial interconnect. Each segment is bounded by two limits at once. The first is the negotiated size cap, which is the payload cap for writes and the read-request cap for reads. The second is the distance to the next 4 KB address page. Every segment therefore ends at whichever of the two comes first, or at the end of the transfer.

Each header goes out on a valid/ready channel. It carries the segment address, its length in 4-byte words, a flag that selects the long (four-word) header form, and a tag. Reads are non-posted. Each read draws a tag from a pool of 32 and holds it until the completion logic returns it through a release strobe. When the pool is empty, read issue stalls. Writes are posted and go out without a tag. A one-cycle pulse marks the end of each descriptor. A malformed descriptor produces an error pulse and no headers.

Top module: `dma_req_splitter`

## Requirements
- R1: A write segment never exceeds the payload cap. The cap is 128 << `mps_code` bytes for codes 0..5, and codes 6 and 7 are clamped to 4096 bytes.
- R2: A read segment never exceeds the read-request cap. It uses the same encoding and clamp on `mrrs_code`.
- R3: No segment spans a 4 KB address page. Segments start at the descriptor address, follow one another with no gap, and together cover exactly the byte count.
- R4: `hdr_len_dw` gives the segment length in 4-byte words (1..1024), not in bytes.
- R5: `hdr_fmt4` is 1 exactly when bits 63:32 of `hdr_addr` are not all zero.
- R6: A descriptor with address bits 1:0 nonzero, byte-count bits 1:0 nonzero, or a zero byte count raises `desc_err` for one cycle and issues no header.
- R7: Each read takes the lowest-numbered free tag out of 32. `hdr_valid` stays low for a read while no tag is free. A `cpl_rel_valid` pulse frees `cpl_rel_tag` for reuse.
- R8: Write headers carry tag 0, consume no tag, and issue even when the tag pool is empty.
- R9: While `hdr_valid` is high and `hdr_ready` is low, `hdr_valid` and all header fields hold their values.
- R10: `seg_done` pulses for one cycle, in the cycle after the handshake of the last segment. `desc_ready` is high only when no descriptor is being processed.
- R11: After reset, `desc_ready` is 1, `hdr_valid`, `seg_done` and `desc_err` are 0, and all 32 tags are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mps_code | input | 3 | Payload cap code for writes, latched at descriptor accept |
| mrrs_code | input | 3 | Read-request cap code for reads, latched at descriptor accept |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor taken this cycle if valid |
| desc_addr | input | 64 | Transfer start byte address |
| desc_bytes | input | 24 | Transfer length in bytes |
| desc_is_write | input | 1 | 1 = write transfer, 0 = read transfer |
| hdr_valid | output | 1 | Header offered |
| hdr_ready | input | 1 | Downstream takes the header |
| hdr_addr | output | 64 | Segment start address |
| hdr_len_dw | output | 11 | Segment length in 4-byte words |
| hdr_fmt4 | output | 1 | 1 = four-word header form |
| hdr_is_write | output | 1 | 1 = posted write segment |
| hdr_tag | output | 5 | Request tag (0 for writes) |
| cpl_rel_valid | input | 1 | Release strobe for a finished read |
| cpl_rel_tag | input | 5 | Tag being released |
| seg_done | output | 1 | Descriptor finished (one-cycle pulse) |
| desc_err | output | 1 | Descriptor rejected (one-cycle pulse) |

## Verification
A corrupted remaining-count or address register would show in the very next header. The address would break contiguity, or the length would exceed a cap or run past a page, and the bench compares every header against an independently computed segment list. A tag pool that leaks entries or fails to mark them used shows up within 32 reads, as a duplicated tag, a wrong lowest-free choice, or a stall that never ends. A stall that was missed shows as an extra header. A faulty end-of-transfer decision shows up at once, as a `seg_done` pulse that arrives early, late or not at all relative to the last handshake.

// File: rtl/dmaseg_pkg.sv
package dmaseg_pkg;

   localparam int PAGE_BYTES = 4096;
   localparam int PAGE_LSB_W = 12;
   localparam int SIZE_W     = 13;
   localparam int MAX_CODE   = 5;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seg_state_e;

   // Cap encoding: 128 bytes shifted left by the code, clamped at one page.
   function automatic logic [SIZE_W-1:0] cap_from_code(input logic [2:0] code);
      if (code >= 3'(MAX_CODE)) return SIZE_W'(PAGE_BYTES);
      return SIZE_W'(128) << code;
   endfunction

endpackage

// File: rtl/dmaseg_len_calc.sv
module dmaseg_len_calc
   import dmaseg_pkg::*;
#(
   parameter int BC_W = 24
) (
   input  logic [PAGE_LSB_W-1:0] addr_lo,
   input  logic [BC_W-1:0]       rem_bytes,
   input  logic [SIZE_W-1:0]     cap_bytes,
   output logic [SIZE_W-1:0]     seg_bytes
);

   logic [SIZE_W-1:0] room;
   logic [SIZE_W-1:0] bound;
   logic [BC_W-1:0]   bound_ext;

   initial begin
      if (BC_W < SIZE_W) $error("dmaseg_len_calc: BC_W must be at least %0d", SIZE_W);
   end

   always_comb begin
      room      = SIZE_W'(PAGE_BYTES) - {1'b0, addr_lo};
      bound     = (cap_bytes < room) ? cap_bytes : room;
      bound_ext = BC_W'(bound);
      seg_bytes = (rem_bytes > bound_ext) ? bound : rem_bytes[SIZE_W-1:0];
   end

endmodule

// File: rtl/dmaseg_tag_pool.sv
module dmaseg_tag_pool #(
   parameter int TAG_N = 32,
   localparam int TAG_W = $clog2(TAG_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rel_en,
   input  logic [TAG_W-1:0] rel_tag,
   input  logic             take_en,
   input  logic [TAG_W-1:0] take_tag,
   output logic             any_free,
   output logic [TAG_W-1:0] low_free
);

   logic [TAG_N-1:0] free_q;

   initial begin
      if (TAG_N < 2) $error("dmaseg_tag_pool: TAG_N must be at least 2");
      if ((1 << TAG_W) != TAG_N) $error("dmaseg_tag_pool: TAG_N must be a power of two");
   end

   for (genvar g = 0; g < TAG_N; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            free_q[g] <= 1'b1;
         end else if (take_en && take_tag == TAG_W'(g)) begin
            free_q[g] <= 1'b0;
         end else if (rel_en && rel_tag == TAG_W'(g)) begin
            free_q[g] <= 1'b1;
         end
      end
   end

   always_comb begin
      low_free = '0;
      for (int i = TAG_N - 1; i >= 0; i--) begin
         if (free_q[i]) low_free = TAG_W'(i);
      end
   end

   assign any_free = |free_q;

   // R7: a tag is only handed out while it is free
   assert_take_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take_en |-> free_q[take_tag]);

   // R7: a taken tag is marked used on the following cycle
   assert_take_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take_en |=> !free_q[$past(take_tag)]);

endmodule

// File: rtl/dma_req_splitter.sv
module dma_req_splitter
   import dmaseg_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int BC_W   = 24,
   parameter int TAG_N  = 32,
   localparam int TAG_W = $clog2(TAG_N),
   localparam int DW_W  = SIZE_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mps_code,
   input  logic [2:0]        mrrs_code,
   input  logic              desc_valid,
   output logic              desc_ready,
   input  logic [ADDR_W-1:0] desc_addr,
   input  logic [BC_W-1:0]   desc_bytes,
   input  logic              desc_is_write,
   output logic              hdr_valid,
   input  logic              hdr_ready,
   output logic [ADDR_W-1:0] hdr_addr,
   output logic [DW_W-1:0]   hdr_len_dw,
   output logic              hdr_fmt4,
   output logic              hdr_is_write,
   output logic [TAG_W-1:0]  hdr_tag,
   input  logic              cpl_rel_valid,
   input  logic [TAG_W-1:0]  cpl_rel_tag,
   output logic              seg_done,
   output logic              desc_err
);

   initial begin
      if (ADDR_W <= 32 || ADDR_W > 64) $error("dma_req_splitter: ADDR_W must be 33..64");
      if (BC_W < SIZE_W) $error("dma_req_splitter: BC_W too small");
   end

   seg_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BC_W-1:0]   rem_q;
   logic              wr_q;
   logic [SIZE_W-1:0] cap_q;
   logic              done_q;
   logic              err_q;
   logic              hold_q;
   logic [TAG_W-1:0]  held_tag_q;

   logic              accept;
   logic              bad_desc;
   logic [SIZE_W-1:0] seg_bytes;
   logic              fire;
   logic              last_seg;
   logic              pool_any;
   logic [TAG_W-1:0]  pool_low;
   logic [TAG_W-1:0]  tag_sel;

   assign desc_ready = (state_q == ST_IDLE);
   assign accept     = desc_ready && desc_valid;
   assign bad_desc   = (desc_addr[1:0] != 2'b00) || (desc_bytes[1:0] != 2'b00) ||
                       (desc_bytes == '0);

   dmaseg_len_calc #(.BC_W(BC_W)) u_len (
      .addr_lo   (addr_q[PAGE_LSB_W-1:0]),
      .rem_bytes (rem_q),
      .cap_bytes (cap_q),
      .seg_bytes (seg_bytes)
   );

   dmaseg_tag_pool #(.TAG_N(TAG_N)) u_pool (
      .clk      (clk),
      .rst_n    (rst_n),
      .rel_en   (cpl_rel_valid),
      .rel_tag  (cpl_rel_tag),
      .take_en  (fire && !wr_q),
      .take_tag (tag_sel),
      .any_free (pool_any),
      .low_free (pool_low)
   );

   assign tag_sel      = hold_q ? held_tag_q : pool_low;
   assign hdr_valid    = (state_q == ST_RUN) && (wr_q || pool_any);
   assign hdr_addr     = addr_q;
   assign hdr_len_dw   = seg_bytes[SIZE_W-1:2];
   assign hdr_fmt4     = |addr_q[ADDR_W-1:32];
   assign hdr_is_write = wr_q;
   assign hdr_tag      = wr_q ? '0 : tag_sel;
   assign fire         = hdr_valid && hdr_ready;
   assign last_seg     = (rem_q == BC_W'(seg_bytes));
   assign seg_done     = done_q;
   assign desc_err     = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         addr_q     <= '0;
         rem_q      <= '0;
         wr_q       <= 1'b0;
         cap_q      <= SIZE_W'(128);
         done_q     <= 1'b0;
         err_q      <= 1'b0;
         hold_q     <= 1'b0;
         held_tag_q <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (accept) begin
            if (bad_desc) begin
               err_q <= 1'b1;
            end else begin
               state_q <= ST_RUN;
               addr_q  <= desc_addr;
               rem_q   <= desc_bytes;
               wr_q    <= desc_is_write;
               cap_q   <= desc_is_write ? cap_from_code(mps_code) : cap_from_code(mrrs_code);
            end
         end
         if (fire) begin
            hold_q <= 1'b0;
            addr_q <= addr_q + ADDR_W'(seg_bytes);
            rem_q  <= rem_q - BC_W'(seg_bytes);
            if (last_seg) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
         end else if (hdr_valid && !wr_q) begin
            hold_q     <= 1'b1;
            held_tag_q <= tag_sel;
         end
      end
   end

   // R9: an offered header is held until taken
   assert_hold_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_addr) &&
      $stable(hdr_len_dw) && $stable(hdr_tag) && $stable(hdr_is_write));

   // R1, R2: segment length against the latched cap
   assert_cap_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> ({hdr_len_dw, 2'b00} <= cap_q) && (hdr_len_dw != '0));

   // R3: segment ends at or before the page edge
   assert_no_page_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> (14'(hdr_addr[PAGE_LSB_W-1:0]) + 14'({hdr_len_dw, 2'b00})) <= 14'(PAGE_BYTES));

   // R10: done is a single-cycle pulse and never coincides with an error
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      seg_done |=> !seg_done);
   assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(seg_done && desc_err));

   // R8: writes never carry a tag
   assert_write_tag_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_is_write |-> hdr_tag == '0);

endmodule

// File: tb/dma_req_splitter_bench.sv
module dma_req_splitter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mps_code = 3'd0;
   logic [2:0]  mrrs_code = 3'd0;
   logic        desc_valid = 1'b0;
   logic        desc_ready;
   logic [63:0] desc_addr = '0;
   logic [23:0] desc_bytes = '0;
   logic        desc_is_write = 1'b0;
   logic        hdr_valid;
   logic        hdr_ready = 1'b1;
   logic [63:0] hdr_addr;
   logic [10:0] hdr_len_dw;
   logic        hdr_fmt4;
   logic        hdr_is_write;
   logic [4:0]  hdr_tag;
   logic        cpl_rel_valid = 1'b0;
   logic [4:0]  cpl_rel_tag = '0;
   logic        seg_done;
   logic        desc_err;

   always #5 clk = ~clk;

   dma_req_splitter u_dma_req_splitter (
      .clk(clk), .rst_n(rst_n), .mps_code(mps_code), .mrrs_code(mrrs_code),
      .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
      .desc_bytes(desc_bytes), .desc_is_write(desc_is_write),
      .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_addr(hdr_addr),
      .hdr_len_dw(hdr_len_dw), .hdr_fmt4(hdr_fmt4), .hdr_is_write(hdr_is_write),
      .hdr_tag(hdr_tag), .cpl_rel_valid(cpl_rel_valid), .cpl_rel_tag(cpl_rel_tag),
      .seg_done(seg_done), .desc_err(desc_err)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int rec_n = 0;
   int done_n = 0;
   int err_n = 0;
   int last_hs_cyc = 0;
   int done_cyc = 0;
   logic [63:0] r_addr [0:127];
   logic [10:0] r_len  [0:127];
   logic        r_fmt4 [0:127];
   logic        r_wr   [0:127];
   logic [4:0]  r_tag  [0:127];

   always @(posedge clk) cyc <= cyc + 1;

   // monitor samples one ns after the falling edge, inputs are already settled
   always begin
      @(negedge clk);
      #1;
      if (rst_n) begin
         if (hdr_valid && hdr_ready && rec_n < 128) begin
            r_addr[rec_n] = hdr_addr;
            r_len[rec_n]  = hdr_len_dw;
            r_fmt4[rec_n] = hdr_fmt4;
            r_wr[rec_n]   = hdr_is_write;
            r_tag[rec_n]  = hdr_tag;
            rec_n = rec_n + 1;
            last_hs_cyc = cyc;
         end
         if (seg_done) begin
            done_n = done_n + 1;
            done_cyc = cyc;
         end
         if (desc_err) err_n = err_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      desc_valid = 1'b0;
      hdr_ready = 1'b1;
      cpl_rel_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rec_n = 0;
      done_n = 0;
      err_n = 0;
   endtask

   task automatic send(input logic [63:0] a, input logic [23:0] n, input bit wr,
                       input logic [2:0] mc, input logic [2:0] rc);
      @(negedge clk);
      mps_code = mc;
      mrrs_code = rc;
      desc_addr = a;
      desc_bytes = n;
      desc_is_write = wr;
      desc_valid = 1'b1;
      @(negedge clk);
      desc_valid = 1'b0;
   endtask

   task automatic wait_end(input int before_done, input int before_err);
      for (int i = 0; i < 2000; i++) begin
         if (done_n != before_done || err_n != before_err) break;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic release_tag(input logic [4:0] t);
      @(negedge clk);
      cpl_rel_tag = t;
      cpl_rel_valid = 1'b1;
      @(negedge clk);
      cpl_rel_valid = 1'b0;
   endtask

   function automatic int cap_of(input logic [2:0] c);
      return (c >= 3'd5) ? 4096 : (128 << c);
   endfunction

   // independent segment model: compares recorded headers from index 'first'
   task automatic cmp_segments(input string req, input int first, input logic [63:0] a,
                               input int n, input int cap, input bit wr, input int tag0);
      logic [63:0] ea = a;
      int rem = n;
      int idx = first;
      int k = 0;
      while (rem > 0) begin
         int room = 4096 - int'(ea[11:0]);
         int len = rem;
         if (len > cap) len = cap;
         if (len > room) len = room;
         if (idx >= rec_n) begin
            chk(1'b0, req, rec_n, idx + 1);
            return;
         end
         chk(r_addr[idx] == ea, req, r_addr[idx], ea);
         chk(int'(r_len[idx]) == len / 4, req, r_len[idx], len / 4);
         chk(r_fmt4[idx] == (ea[63:32] != 0), {req, " R5"}, r_fmt4[idx], ea[63:32] != 0);
         chk(r_wr[idx] == wr, req, r_wr[idx], wr);
         chk(int'(r_tag[idx]) == (wr ? 0 : tag0 + k), {req, " tag"}, r_tag[idx],
             wr ? 0 : tag0 + k);
         ea = ea + 64'(len);
         rem = rem - len;
         idx++;
         k++;
      end
      chk(rec_n == idx, {req, " segment count"}, rec_n, idx);
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk); #1;
      chk(desc_ready == 1'b1, "R11 desc_ready", desc_ready, 1);
      chk(hdr_valid == 1'b0, "R11 hdr_valid", hdr_valid, 0);
      chk(seg_done == 1'b0 && desc_err == 1'b0, "R11 pulses", {seg_done, desc_err}, 0);
   endtask

   task automatic t_write_mps();
      do_reset();
      send(64'h1000, 24'd1000, 1'b1, 3'd0, 3'd3);
      wait_end(0, 0);
      cmp_segments("R1 R4 write 128B cap", 0, 64'h1000, 1000, 128, 1'b1, 0);
      chk(done_n == 1, "R10 one done", done_n, 1);
      chk(done_cyc == last_hs_cyc + 1, "R10 done timing", done_cyc, last_hs_cyc + 1);
   endtask

   task automatic t_read_page();
      do_reset();
      send(64'h1_0000_1F80, 24'd1024, 1'b0, 3'd0, 3'd2);
      wait_end(0, 0);
      cmp_segments("R2 R3 read across page", 0, 64'h1_0000_1F80, 1024, 512, 1'b0, 0);
      do_reset();
      send(64'h0, 24'd8192, 1'b1, 3'd7, 3'd0);
      wait_end(0, 0);
      cmp_segments("R1 clamp code 7", 0, 64'h0, 8192, 4096, 1'b1, 0);
      chk(r_len[0] == 11'd1024, "R4 full page length", r_len[0], 1024);
   endtask

   task automatic t_errors();
      do_reset();
      send(64'h1002, 24'd64, 1'b1, 3'd0, 3'd0);
      wait_end(0, 0);
      send(64'h1000, 24'd62, 1'b0, 3'd0, 3'd0);
      wait_end(0, 1);
      send(64'h1000, 24'd0, 1'b1, 3'd0, 3'd0);
      wait_end(0, 2);
      chk(err_n == 3, "R6 error pulses", err_n, 3);
      chk(rec_n == 0, "R6 no headers", rec_n, 0);
      chk(done_n == 0, "R6 no done", done_n, 0);
      chk(desc_ready == 1'b1, "R10 idle after error", desc_ready, 1);
   endtask

   task automatic t_tags();
      do_reset();
      send(64'h0, 24'd4096, 1'b0, 3'd0, 3'd0);
      wait_end(0, 0);
      cmp_segments("R7 32 tags in order", 0, 64'h0, 4096, 128, 1'b0, 0);
      send(64'h2000, 24'd256, 1'b1, 3'd0, 3'd0);
      wait_end(1, 0);
      cmp_segments("R8 write with empty pool", 32, 64'h2000, 256, 128, 1'b1, 0);
      send(64'h3000, 24'd256, 1'b0, 3'd0, 3'd0);
      repeat (6) @(negedge clk);
      #1;
      chk(rec_n == 34, "R7 stall without tag", rec_n, 34);
      chk(hdr_valid == 1'b0, "R7 valid low when empty", hdr_valid, 0);
      release_tag(5'd7);
      repeat (3) @(negedge clk);
      chk(rec_n == 35, "R7 issue after release", rec_n, 35);
      chk(r_tag[34] == 5'd7, "R7 released tag reused", r_tag[34], 7);
      release_tag(5'd3);
      wait_end(2, 0);
      chk(rec_n == 36, "R7 second issue", rec_n, 36);
      chk(r_tag[35] == 5'd3, "R7 second released tag", r_tag[35], 3);
      chk(r_addr[35] == 64'h3080, "R3 contiguous after stall", r_addr[35], 64'h3080);
      chk(done_n == 3, "R10 done after stalled read", done_n, 3);
   endtask

   task automatic t_backpressure();
      logic [63:0] a0;
      logic [10:0] l0;
      do_reset();
      hdr_ready = 1'b0;
      send(64'h40, 24'd256, 1'b1, 3'd1, 3'd0);
      @(negedge clk); #1;
      a0 = hdr_addr;
      l0 = hdr_len_dw;
      chk(hdr_valid == 1'b1, "R9 valid offered", hdr_valid, 1);
      chk(desc_ready == 1'b0, "R10 busy", desc_ready, 0);
      repeat (4) @(negedge clk);
      #1;
      chk(hdr_valid == 1'b1 && hdr_addr == a0 && hdr_len_dw == l0, "R9 held",
          hdr_addr, a0);
      chk(a0 == 64'h40 && l0 == 11'd64, "R9 first segment", {a0[15:0], 5'd0, l0}, 64'h400040);
      @(negedge clk);
      hdr_ready = 1'b1;
      wait_end(0, 0);
      cmp_segments("R9 R1 after backpressure", 0, 64'h40, 256, 256, 1'b1, 0);
   endtask

   initial begin
      t_reset();
      t_write_mps();
      t_read_page();
      t_errors();
      t_tags();
      t_backpressure();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait (cyc > 100000);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule